// File: doc/BRIEF.md
# Multi-bank SDRAM command sequencer

This block sits on the controller side of a double-data-rate SDRAM with four banks. It takes column-level read and write requests, each naming a bank, a row and a column, and turns them into a legal stream of device commands. It issues one command per clock. It keeps a record of which row is open in each bank, opens and closes rows as requests need them, and brings the device up after reset. A timer schedules refreshes. A low-power request puts the device into self-refresh and takes it out again.

Requests arrive on a valid/ready handshake. The requester holds `req_valid` and all request fields stable until it sees `req_ready` high at a rising edge. `req_ready` rises only in the cycle that the read or write command for that request goes out, so any stall inside the sequencer back-pressures the requester. `req_ready` may depend on `req_valid` in the same cycle. The low-power request and the clock-enable output are plain level signals. The command bus is combinational from registered state plus the request inputs, and shows a no-operation in every cycle where no command is issued.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is high the bus shows no-operation, `cke` is 1 and `req_ready` is 0. After reset the sequencer issues the following, in this order: a precharge of all banks, two auto refreshes, and one mode register set. It issues them before any activate and before it asserts `req_ready`.
- R2: Command codes on `cmd` are: 0 no-operation, 1 mode set, 2 activate, 3 read, 4 write, 5 precharge, 6 burst stop, 7 auto refresh, 8 self-refresh entry, 9 self-refresh exit. `cmd_ap` set with a precharge means all banks. `cmd_ap` set with a read or write means auto-precharge. Unused fields are zero.
- R3: The mode set carries the burst-length code log2(BURST_LEN) in `cmd_addr[2:0]`, 0 (sequential) in bit 3, and CAS_LAT (2 or 3) in bits 6:4.
- R4: A request to an idle bank first gets an activate carrying the row. Its column command follows T_RCD cycles later.
- R5: A request to a bank whose open row is a different row gets a precharge of that bank, then an activate T_RP cycles later.
- R6: A request to the open row goes straight to its column command. Reads without auto-precharge may issue on consecutive clocks.
- R7: A write requested while a read burst is still in flight is preceded by a burst stop. The write issues CAS_LAT cycles after the burst stop. A read burst counts as in flight for CAS_LAT + BURST_LEN/2 cycles after the read.
- R8: A column command with auto-precharge leaves its bank idle. The next command of any kind issues BURST_LEN/2 + T_RP cycles later. After a plain write the gap is BURST_LEN/2 cycles.
- R9: A refresh falls due every REFI_CLKS clocks and takes priority over low-power and new requests. If any bank is open, all banks are precharged first. An auto refresh issues only when all banks are idle, and the next command follows T_RFC cycles later.
- R10: No precharge and no self-refresh entry issues while a read burst is in flight.
- R11: A low-power request closes any open banks and then issues self-refresh entry, with `cke` low from that cycle on. When the request drops, self-refresh exit issues with `cke` high. The next command follows T_XSR cycles later.
- R12: `req_ready` is high exactly in the cycles that carry the read or write of the presented request. Every presented request is accepted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_autopre | input | 1 | Close the bank after this access |
| lp_req | input | 1 | Low-power (self-refresh) request |
| cke | output | 1 | Clock enable to the device |
| cmd | output | 4 | Command code (R2) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | ADDR_W | Row, column or mode word |
| cmd_ap | output | 1 | All-banks / auto-precharge flag |

## Verification
On every cycle the assertions check these command legality rules: activates only to idle banks, column commands only to open banks, refresh only with every bank closed, and a quiet cycle after each burst stop. They also check that the refresh request holds until served, that clock enable stays low until exit, and that an open bank's row does not move. Only the bench's scenarios can show the exact spacing between commands. The same holds for the order of precharge, activate and column command on a row miss, the burst-stop turnaround before a write, and refresh pre-empting a waiting request. It also holds for the complete bring-up order and for every request being accepted exactly once.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'd0, CMD_MRS = 4'd1, CMD_ACT = 4'd2, CMD_RD  = 4'd3, CMD_WR = 4'd4,
    CMD_PRE = 4'd5, CMD_BST = 4'd6, CMD_REF = 4'd7, CMD_SRE = 4'd8, CMD_SRX = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    S_BOOT, S_IREF, S_MRS, S_IDLE, S_SREF
  } seq_st_e;
endpackage

// File: rtl/sdq_bank_table.sv
module sdq_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             act_en,
  input  logic [BANK_W-1:0]                act_bank,
  input  logic [ROW_W-1:0]                 act_row,
  input  logic                             close_en,
  input  logic [BANK_W-1:0]                close_bank,
  input  logic                             close_all,
  output logic [NUM_BANKS-1:0]             open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  row_o
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit_act, hit_close;
    assign hit_act   = act_en && (act_bank == BANK_W'(i));
    assign hit_close = close_all || (close_en && (close_bank == BANK_W'(i)));

    always_ff @(posedge clk) begin
      if (rst) begin
        open_o[i] <= 1'b0;
        row_o[i]  <= '0;
      end else if (hit_act) begin
        open_o[i] <= 1'b1;
        row_o[i]  <= act_row;
      end else if (hit_close) begin
        open_o[i] <= 1'b0;
      end
    end

    // R5
    row_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (open_o[i] && !hit_act) |=> $stable(row_o[i]));
  end
endmodule

// File: rtl/sdq_refresh_timer.sv
module sdq_refresh_timer #(
  parameter int REFI_CLKS = 1560,
  localparam int CNT_W    = $clog2(REFI_CLKS)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic pend
);
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = (cnt == CNT_W'(REFI_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      pend <= tick || (pend && !clr);
    end
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int T_XSR     = 20,
  parameter int REFI_CLKS = 1560,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  input  logic              lp_req,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap
);
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int RD_WIN    = CAS_LAT + BURST_CYC;
  localparam int GAP_MAX   = T_RFC + T_XSR + T_RCD + T_MRD + BURST_CYC + T_RP + CAS_LAT;
  localparam int WC_W      = $clog2(GAP_MAX + 1);
  localparam int RC_W      = $clog2(RD_WIN + 1);
  localparam int BL_CODE   = $clog2(BURST_LEN);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'((CAS_LAT << 4) | BL_CODE);

  seq_st_e          st, st_n;
  logic [WC_W-1:0]  wcnt, wcnt_n;
  logic [RC_W-1:0]  rd_cnt, rd_cnt_n;
  logic             icnt, icnt_n;
  cmd_e             cmd_c;

  logic                            act_en, pre_one, pre_all, ap_close, ref_clr, rd_set, bst_set;
  logic [NUM_BANKS-1:0]            bank_open;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
  logic                            ref_pend, busy, any_open, row_hit;

  sdq_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst(rst),
    .act_en(act_en), .act_bank(req_bank), .act_row(req_row),
    .close_en(pre_one || ap_close), .close_bank(req_bank), .close_all(pre_all),
    .open_o(bank_open), .row_o(bank_row)
  );

  sdq_refresh_timer #(.REFI_CLKS(REFI_CLKS)) u_refi (
    .clk(clk), .rst(rst), .clr(ref_clr), .pend(ref_pend)
  );

  assign busy     = (rd_cnt != '0);
  assign any_open = |bank_open;
  assign row_hit  = bank_open[req_bank] && (bank_row[req_bank] == req_row);
  assign cmd      = cmd_c;

  always_comb begin
    cmd_c    = CMD_NOP;
    cmd_bank = '0;
    cmd_addr = '0;
    cmd_ap   = 1'b0;
    req_ready = 1'b0;
    cke      = (st != S_SREF);
    st_n     = st;
    icnt_n   = icnt;
    wcnt_n   = (wcnt != '0) ? wcnt - 1'b1 : '0;
    act_en = 1'b0; pre_one = 1'b0; pre_all = 1'b0; ap_close = 1'b0;
    ref_clr = 1'b0; rd_set = 1'b0; bst_set = 1'b0;
    if (!rst && wcnt == '0) begin
      unique case (st)
        S_BOOT: begin
          cmd_c = CMD_PRE; cmd_ap = 1'b1; pre_all = 1'b1;
          wcnt_n = WC_W'(T_RP - 1); st_n = S_IREF;
        end
        S_IREF: begin
          cmd_c = CMD_REF; ref_clr = 1'b1;
          wcnt_n = WC_W'(T_RFC - 1);
          icnt_n = icnt + 1'b1;
          if (icnt) st_n = S_MRS;
        end
        S_MRS: begin
          cmd_c = CMD_MRS; cmd_addr = MODE_WORD;
          wcnt_n = WC_W'(T_MRD - 1); st_n = S_IDLE;
        end
        S_SREF: begin
          if (!lp_req) begin
            cmd_c = CMD_SRX; cke = 1'b1;
            wcnt_n = WC_W'(T_XSR - 1); st_n = S_IDLE;
          end
        end
        S_IDLE: begin
          if (ref_pend) begin
            if (any_open) begin
              if (!busy) begin
                cmd_c = CMD_PRE; cmd_ap = 1'b1; pre_all = 1'b1;
                wcnt_n = WC_W'(T_RP - 1);
              end
            end else begin
              cmd_c = CMD_REF; ref_clr = 1'b1;
              wcnt_n = WC_W'(T_RFC - 1);
            end
          end else if (lp_req) begin
            if (!busy) begin
              if (any_open) begin
                cmd_c = CMD_PRE; cmd_ap = 1'b1; pre_all = 1'b1;
                wcnt_n = WC_W'(T_RP - 1);
              end else begin
                cmd_c = CMD_SRE; cke = 1'b0; st_n = S_SREF;
              end
            end
          end else if (req_valid) begin
            if (row_hit) begin
              if (req_write && busy) begin
                cmd_c = CMD_BST; bst_set = 1'b1;
                wcnt_n = WC_W'(CAS_LAT - 1);
              end else begin
                cmd_c = req_write ? CMD_WR : CMD_RD;
                cmd_bank = req_bank;
                cmd_addr = ADDR_W'(req_col);
                cmd_ap = req_autopre;
                req_ready = 1'b1;
                rd_set = !req_write;
                if (req_autopre) begin
                  ap_close = 1'b1;
                  wcnt_n = WC_W'(BURST_CYC + T_RP - 1);
                end else if (req_write) begin
                  wcnt_n = WC_W'(BURST_CYC - 1);
                end else begin
                  wcnt_n = '0;
                end
              end
            end else if (bank_open[req_bank]) begin
              if (!busy) begin
                cmd_c = CMD_PRE; cmd_bank = req_bank; pre_one = 1'b1;
                wcnt_n = WC_W'(T_RP - 1);
              end
            end else begin
              cmd_c = CMD_ACT; cmd_bank = req_bank;
              cmd_addr = ADDR_W'(req_row); act_en = 1'b1;
              wcnt_n = WC_W'(T_RCD - 1);
            end
          end
        end
        default: st_n = S_BOOT;
      endcase
    end
  end

  always_comb begin
    if (bst_set)              rd_cnt_n = '0;
    else if (rd_set)          rd_cnt_n = RC_W'(RD_WIN);
    else if (rd_cnt != '0)    rd_cnt_n = rd_cnt - 1'b1;
    else                      rd_cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_BOOT;
      wcnt   <= '0;
      rd_cnt <= '0;
      icnt   <= 1'b0;
    end else begin
      st     <= st_n;
      wcnt   <= wcnt_n;
      rd_cnt <= rd_cnt_n;
      icnt   <= icnt_n;
    end
  end

  // R4
  act_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_ACT) |-> !bank_open[cmd_bank]);
  // R6
  col_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_RD || cmd_c == CMD_WR) |-> bank_open[cmd_bank]);
  // R9
  ref_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_REF) |-> (bank_open == '0));
  // R7
  bst_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_BST) |=> (cmd_c == CMD_NOP));
  // R11
  cke_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |=> (cmd_c == CMD_NOP || cmd_c == CMD_SRX));
  // R10
  pre_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_RD) |=> (cmd_c != CMD_PRE && cmd_c != CMD_SRE));
endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, ROW_W = 12, COL_W = 8, BL = 4, CL = 3;
  localparam int T_RCD = 3, T_RP = 3, T_RFC = 10, T_MRD = 2, T_XSR = 20, REFI = 250;
  localparam int BC = BL / 2;
  localparam int MODE = (CL << 4) | 2;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_autopre = 0, lp_req = 0;
  logic [1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic req_ready, cke, cmd_ap;
  logic [3:0] cmd;
  logic [1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_addr;

  sdram_cmd_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BL),
    .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .T_XSR(T_XSR), .REFI_CLKS(REFI)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .lp_req(lp_req), .cke(cke), .cmd(cmd),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit wr; int b; int row; int col; bit ap; } req_t;
  req_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  int next_ok = 0, rd_until = 0, phase = 0, irefs = 0, sref = 0;
  bit pend = 0;
  int m_open[NB], m_row[NB];
  int e_cmd, e_bank, e_addr, e_ap, e_ready, e_cke;

  int n_mrs = 0, n_ref = 0, n_bst = 0, n_sre = 0, n_srx = 0, n_pre1 = 0, n_ap = 0;
  int n_acc = 0, n_b2b = 0, n_req = 0;
  bit prev_rd = 0, early_act = 0;

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic close_all();
    for (int i = 0; i < NB; i++) m_open[i] = 0;
  endtask

  task automatic model(input int c, input bit v, input req_t r, input bit lp);
    bit busy, any;
    e_cmd = 0; e_bank = 0; e_addr = 0; e_ap = 0; e_ready = 0;
    e_cke = sref ? 0 : 1;
    if (c > 0 && c % REFI == 0) pend = 1;
    busy = (c < rd_until);
    any = 0;
    for (int i = 0; i < NB; i++) if (m_open[i] != 0) any = 1;
    if (sref != 0) begin
      if (!lp) begin e_cmd = 9; e_cke = 1; next_ok = c + T_XSR; sref = 0; end
    end else if (c >= next_ok) begin
      if (phase == 0) begin
        e_cmd = 5; e_ap = 1; close_all(); next_ok = c + T_RP; phase = 1;
      end else if (phase == 1) begin
        e_cmd = 7; pend = 0; next_ok = c + T_RFC; irefs++;
        if (irefs == 2) phase = 2;
      end else if (phase == 2) begin
        e_cmd = 1; e_addr = MODE; next_ok = c + T_MRD; phase = 3;
      end else if (pend) begin
        if (any) begin
          if (!busy) begin e_cmd = 5; e_ap = 1; close_all(); next_ok = c + T_RP; end
        end else begin
          e_cmd = 7; pend = 0; next_ok = c + T_RFC;
        end
      end else if (lp) begin
        if (!busy) begin
          if (any) begin e_cmd = 5; e_ap = 1; close_all(); next_ok = c + T_RP; end
          else begin e_cmd = 8; e_cke = 0; sref = 1; end
        end
      end else if (v) begin
        if (m_open[r.b] != 0 && m_row[r.b] == r.row) begin
          if (r.wr && busy) begin
            e_cmd = 6; rd_until = 0; next_ok = c + CL;
          end else begin
            e_cmd = r.wr ? 4 : 3; e_bank = r.b; e_addr = r.col; e_ap = r.ap; e_ready = 1;
            if (r.ap) begin m_open[r.b] = 0; next_ok = c + BC + T_RP; end
            else next_ok = c + (r.wr ? BC : 1);
            if (!r.wr) rd_until = c + CL + BC + 1;
          end
        end else if (m_open[r.b] != 0) begin
          if (!busy) begin e_cmd = 5; e_bank = r.b; m_open[r.b] = 0; next_ok = c + T_RP; end
        end else begin
          e_cmd = 2; e_bank = r.b; e_addr = r.row; m_open[r.b] = 1; m_row[r.b] = r.row;
          next_ok = c + T_RCD;
        end
      end
    end
  endtask

  function automatic string tag_of(input int c);
    case (c)
      0: return "R10"; 1: return "R3"; 2: return "R4"; 3: return "R6";
      4: return "R8";  5: return "R5"; 6: return "R7"; 7: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired, R12 not completed");
      report();
    end
  end

  initial begin
    int cyc;
    req_t cur;
    // directed requests: ACT+read, hits, read->write turnaround, auto-precharge, row miss
    q.push_back('{0, 0, 5, 1, 0});
    q.push_back('{0, 0, 5, 2, 0});
    q.push_back('{0, 0, 5, 3, 0});
    q.push_back('{1, 0, 5, 4, 0});
    q.push_back('{1, 1, 7, 0, 1});
    q.push_back('{0, 1, 7, 1, 0});
    q.push_back('{0, 0, 9, 5, 0});
    q.push_back('{1, 2, 1, 3, 0});
    q.push_back('{0, 3, 2, 6, 1});
    q.push_back('{1, 3, 2, 7, 0});
    for (int i = 0; i < 50; i++)
      q.push_back('{(i % 3 == 1), i % NB, (i / 5) % 3, i, (i % 7 == 6)});
    n_req = q.size();
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; end

    repeat (2) @(negedge clk);
    // R1: reset state
    chk(cmd == 4'd0, "R1 reset cmd", cmd, 0);
    chk(req_ready == 1'b0, "R1 reset ready", req_ready, 0);
    chk(cke == 1'b1, "R1 reset cke", cke, 1);
    @(negedge clk);
    rst = 0;
    cyc = 0;
    while (!(q.size() == 0 && cyc >= 700) && cyc < 4000) begin
      if (q.size() > 0) begin
        cur = q[0];
        req_valid = 1; req_write = cur.wr; req_bank = 2'(cur.b);
        req_row = ROW_W'(cur.row); req_col = COL_W'(cur.col); req_autopre = cur.ap;
      end else begin
        cur = '{0, 0, 0, 0, 0};
        req_valid = 0; req_write = 0; req_bank = 0; req_row = 0; req_col = 0; req_autopre = 0;
      end
      lp_req = (cyc >= 500 && cyc < 560);
      #1;
      model(cyc, req_valid, cur, lp_req);
      checks++;
      if (cmd != 4'(e_cmd) || cmd_bank != 2'(e_bank) || cmd_addr != ROW_W'(e_addr) ||
          cmd_ap != e_ap[0] || req_ready != e_ready[0] || cke != e_cke[0]) begin
        errors++;
        $display("FAIL %s cyc %0d actual cmd/bank/addr/ap/rdy/cke %0d/%0d/%0h/%0d/%0d/%0d expected %0d/%0d/%0h/%0d/%0d/%0d",
          (req_ready != e_ready[0]) ? "R12" : (cke != e_cke[0]) ? "R11" :
          (cmd != 4'(e_cmd)) ? tag_of(e_cmd) : "R2",
          cyc, cmd, cmd_bank, cmd_addr, cmd_ap, req_ready, cke,
          e_cmd, e_bank, e_addr, e_ap, e_ready, e_cke);
      end
      if (cmd == 4'd2 && n_mrs == 0) early_act = 1;
      if (cmd == 4'd1) n_mrs++;
      if (cmd == 4'd7) n_ref++;
      if (cmd == 4'd6) n_bst++;
      if (cmd == 4'd8) n_sre++;
      if (cmd == 4'd9) n_srx++;
      if (cmd == 4'd5 && !cmd_ap) n_pre1++;
      if ((cmd == 4'd3 || cmd == 4'd4) && cmd_ap) n_ap++;
      if (cmd == 4'd3 && prev_rd) n_b2b++;
      prev_rd = (cmd == 4'd3);
      if (e_ready != 0) begin
        n_acc++;
        void'(q.pop_front());
      end
      @(negedge clk);
      cyc++;
    end
    done = 1;
    // R1: bring-up finished with a single mode set and no early activate
    chk(n_mrs == 1 && !early_act, "R1 bring-up order", n_mrs, 1);
    // R3: mode set seen once
    chk(n_mrs == 1, "R3 mode set count", n_mrs, 1);
    // R5: a row miss caused a single-bank precharge
    chk(n_pre1 >= 1, "R5 single-bank precharge", n_pre1, 1);
    // R6: reads on consecutive clocks
    chk(n_b2b >= 1, "R6 back-to-back reads", n_b2b, 1);
    // R7: burst stop before a write after a read
    chk(n_bst >= 1, "R7 burst stop seen", n_bst, 1);
    // R8: auto-precharge commands issued
    chk(n_ap >= 1, "R8 auto-precharge seen", n_ap, 1);
    // R9: init refreshes plus periodic ones
    chk(n_ref >= 4, "R9 refresh count", n_ref, 4);
    // R11: one self-refresh entry and exit
    chk(n_sre == 1 && n_srx == 1, "R11 self-refresh pair", n_sre, 1);
    // R12: every request accepted once
    chk(n_acc == n_req, "R12 accepted count", n_acc, n_req);
    report();
  end
endmodule